// File: doc/BRIEF.md
# Flag Threshold Loader

This block produces the two threshold words that a FIFO's programmable flags compare against. The low threshold (`x_ofs`) is used by the almost-empty flag and the high-side margin (`y_ofs`) by the almost-full flag. Both are `PTR_W` bits wide, where `PTR_W = log2(DEPTH)`.

The loading method is chosen by two dual-purpose input pins. Their level is captured on every clock edge while reset is held low, so the value present at the last edge before reset is released is the one that counts. There are four method codes:

- two fixed preset values;
- a parallel load of two words from the write port;
- a serial load through a single shift chain.

After reset the same two pins take their second role: an active-low serial enable and a serial data bit, both sampled on the write-side clock. Until loading finishes, the block holds input-ready low and keeps write strobes away from the FIFO.

Top module: `ofs_loader`

## Requirements
- R1: The method code `{sel1_sen_n, sel0_sdata}` is captured at the last rising clock edge while `rst_n` is low. Changing the pins after reset has no effect on the chosen method, on `x_ofs`/`y_ofs` or on `ofs_done`.
- R2: Code 2'b00 loads `PRESET_LO` (default 8) into both thresholds. `ofs_done` rises at the first rising edge after `rst_n` goes high.
- R3: Code 2'b01 loads `PRESET_HI` (default 16) into both thresholds. `ofs_done` rises at the first rising edge after `rst_n` goes high.
- R4: Code 2'b11 selects serial loading. Each rising edge with `sel1_sen_n` low shifts in `sel0_sdata`.
  - After 2·`PTR_W` bits, `ofs_done` is high.
  - The first bit lands in the MSB of `y_ofs` and the last bit in the LSB of `x_ofs`.
  - `ofs_done` is still low after 2·`PTR_W`−1 bits.
- R5: In serial mode, edges with `sel1_sen_n` high shift nothing. Bits presented after `ofs_done` change neither threshold.
- R6: Code 2'b10 selects parallel loading. The first `wr_en` after reset loads `x_ofs` from `wr_data[PTR_W-1:0]`. The second loads `y_ofs` and raises `ofs_done`. Later writes leave both thresholds unchanged.
- R7: `in_rdy` equals `ofs_done`. `fifo_wr` is `wr_en` gated by `ofs_done`, so the configuration writes of R6 never reach the FIFO. Once high, `ofs_done` stays high until reset.
- R8: While `rst_n` is low, `ofs_done`, `in_rdy`, `x_ofs` and `y_ofs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; method code sampled while low |
| sel1_sen_n | input | 1 | Method select bit 1 during reset; active-low serial enable afterwards |
| sel0_sdata | input | 1 | Method select bit 0 during reset; serial data afterwards |
| wr_en | input | 1 | Write strobe from the write port |
| wr_data | input | DATA_W | Write-port data; low `PTR_W` bits used for parallel loading |
| x_ofs | output | PTR_W | Almost-empty threshold |
| y_ofs | output | PTR_W | Almost-full threshold |
| ofs_done | output | 1 | Thresholds loaded |
| in_rdy | output | 1 | Input-ready; low until loading is complete |
| fifo_wr | output | 1 | Write strobe passed on to FIFO storage |

## Verification
The bench walks the serial chain one bit at a time to catch an off-by-one count: a design that finished a bit early would raise `ofs_done` after 19 bits, and a reversed chain would put swapped, mirrored values into `x_ofs` and `y_ofs`. Gaps with the serial enable high, and extra bits after completion, are driven with deliberately wrong data, so a loader that ignored the enable or kept shifting would show corrupted thresholds. In parallel mode the bench watches `fifo_wr` on the two configuration writes and on the third write, which catches both leaked config words and a loader that swallows a real write. The pins are also wiggled after a preset reset, which exposes a method latch that keeps sampling outside reset.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   typedef enum logic [1:0] {
      MODE_PRESET_LO = 2'b00,
      MODE_PRESET_HI = 2'b01,
      MODE_PARALLEL  = 2'b10,
      MODE_SERIAL    = 2'b11
   } ofs_mode_e;
endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
   import ofs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   output ofs_mode_e  mode,
   output logic       live
);
   // Track the pins throughout reset; freeze on release.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= ofs_mode_e'(sel);
         live <= 1'b0;
      end else begin
         live <= 1'b1;
      end
   end

   assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      live |=> $stable(mode));
endmodule

// File: rtl/ofs_serial_chain.sv
module ofs_serial_chain #(
   parameter int PTR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             sen_n,
   input  logic             sdata,
   output logic [PTR_W-1:0] x_val,
   output logic [PTR_W-1:0] y_val,
   output logic             done
);
   localparam int NBITS = 2 * PTR_W;
   localparam int CW    = $clog2(NBITS + 1);

   logic [NBITS-1:0] chain;
   logic [CW-1:0]    cnt;
   logic             shift;

   assign done  = (cnt == CW'(NBITS));
   assign shift = arm && !sen_n && !done;

   // One concatenated chain: the upper half is Y, the lower half is X.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         cnt   <= '0;
      end else if (shift) begin
         chain <= {chain[NBITS-2:0], sdata};
         cnt   <= cnt + 1'b1;
      end
   end

   assign y_val = chain[NBITS-1:PTR_W];
   assign x_val = chain[PTR_W-1:0];

   assert_chain_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(chain));
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(NBITS));
endmodule

// File: rtl/ofs_parallel_load.sv
module ofs_parallel_load #(
   parameter int PTR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             wr,
   input  logic [PTR_W-1:0] din,
   output logic [PTR_W-1:0] x_val,
   output logic [PTR_W-1:0] y_val,
   output logic             done
);
   logic got_x;
   logic take;

   assign take = arm && wr && !done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_val <= '0;
         y_val <= '0;
         got_x <= 1'b0;
         done  <= 1'b0;
      end else if (take) begin
         if (!got_x) begin
            x_val <= din;
            got_x <= 1'b1;
         end else begin
            y_val <= din;
            done  <= 1'b1;
         end
      end
   end

   assert_pair_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(x_val) && $stable(y_val)));
   assert_x_before_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> got_x);
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
   import ofs_pkg::*;
#(
   parameter int DEPTH     = 1024,
   parameter int DATA_W    = 36,
   parameter int PRESET_LO = 8,
   parameter int PRESET_HI = 16,
   localparam int PTR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel1_sen_n,
   input  logic              sel0_sdata,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PTR_W-1:0]  x_ofs,
   output logic [PTR_W-1:0]  y_ofs,
   output logic              ofs_done,
   output logic              in_rdy,
   output logic              fifo_wr
);
   // Elaboration-time parameter checks
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (DATA_W < PTR_W) begin : g_bad_width
      $error("DATA_W must cover the threshold width");
   end
   if (PRESET_LO >= DEPTH || PRESET_HI >= DEPTH) begin : g_bad_preset
      $error("preset thresholds must be below DEPTH");
   end

   ofs_mode_e        mode;
   logic             live;
   logic [PTR_W-1:0] s_x, s_y, p_x, p_y;
   logic             s_done, p_done;

   ofs_mode_latch u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   ({sel1_sen_n, sel0_sdata}),
      .mode  (mode),
      .live  (live)
   );

   ofs_serial_chain #(.PTR_W(PTR_W)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (live && mode == MODE_SERIAL),
      .sen_n (sel1_sen_n),
      .sdata (sel0_sdata),
      .x_val (s_x),
      .y_val (s_y),
      .done  (s_done)
   );

   ofs_parallel_load #(.PTR_W(PTR_W)) u_par (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (live && mode == MODE_PARALLEL),
      .wr    (wr_en),
      .din   (wr_data[PTR_W-1:0]),
      .x_val (p_x),
      .y_val (p_y),
      .done  (p_done)
   );

   always_comb begin
      x_ofs    = '0;
      y_ofs    = '0;
      ofs_done = 1'b0;
      if (live) begin
         unique case (mode)
            MODE_PRESET_LO: begin
               x_ofs    = PTR_W'(PRESET_LO);
               y_ofs    = PTR_W'(PRESET_LO);
               ofs_done = 1'b1;
            end
            MODE_PRESET_HI: begin
               x_ofs    = PTR_W'(PRESET_HI);
               y_ofs    = PTR_W'(PRESET_HI);
               ofs_done = 1'b1;
            end
            MODE_PARALLEL: begin
               x_ofs    = p_x;
               y_ofs    = p_y;
               ofs_done = p_done;
            end
            MODE_SERIAL: begin
               x_ofs    = s_x;
               y_ofs    = s_y;
               ofs_done = s_done;
            end
            default: ;
         endcase
      end
   end

   assign in_rdy  = ofs_done;
   assign fifo_wr = wr_en && ofs_done;

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_done |=> ofs_done);
endmodule

// File: tb/sim_ofs_loader.sv
module sim_ofs_loader;
   localparam int DEPTH  = 1024;
   localparam int DATA_W = 36;
   localparam int PTR_W  = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sel1_sen_n = 1'b0;
   logic              sel0_sdata = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [PTR_W-1:0]  x_ofs, y_ofs;
   logic              ofs_done, in_rdy, fifo_wr;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   ofs_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .sel1_sen_n(sel1_sen_n), .sel0_sdata(sel0_sdata),
      .wr_en(wr_en), .wr_data(wr_data), .x_ofs(x_ofs), .y_ofs(y_ofs),
      .ofs_done(ofs_done), .in_rdy(in_rdy), .fifo_wr(fifo_wr)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // Hold reset with a method code, check cleared outputs, release at a negedge.
   task automatic apply_reset(input logic [1:0] code);
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      sel1_sen_n = code[1]; sel0_sdata = code[0];
      repeat (3) @(negedge clk);
      check("R8 done in reset", ofs_done, 0);
      check("R8 in_rdy in reset", in_rdy, 0);
      check("R8 x in reset", x_ofs, 0);
      check("R8 y in reset", y_ofs, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_preset_lo;
      apply_reset(2'b00);
      @(negedge clk);
      check("R2 done", ofs_done, 1);
      check("R2 x", x_ofs, 8);
      check("R2 y", y_ofs, 8);
      check("R7 in_rdy", in_rdy, 1);
   endtask

   task automatic t_preset_hi;
      apply_reset(2'b01);
      @(negedge clk);
      check("R3 done", ofs_done, 1);
      check("R3 x", x_ofs, 16);
      check("R3 y", y_ofs, 16);
   endtask

   task automatic t_pins_after_reset;
      apply_reset(2'b00);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         sel1_sen_n = i[0]; sel0_sdata = i[1];
      end
      @(negedge clk);
      check("R1 x after pin wiggle", x_ofs, 8);
      check("R1 y after pin wiggle", y_ofs, 8);
      check("R1 done after pin wiggle", ofs_done, 1);
   endtask

   task automatic t_serial(input logic [PTR_W-1:0] yv, input logic [PTR_W-1:0] xv, input bit gaps);
      logic [2*PTR_W-1:0] stream;
      stream = {yv, xv};
      apply_reset(2'b11);
      @(negedge clk);
      check("R4 done before bits", ofs_done, 0);
      for (int i = 0; i < 2*PTR_W; i++) begin
         if (gaps && i % 3 == 1) begin
            sel1_sen_n = 1'b1; sel0_sdata = ~stream[2*PTR_W-1-i];
            @(negedge clk);
         end
         sel1_sen_n = 1'b0; sel0_sdata = stream[2*PTR_W-1-i];
         if (i == 2*PTR_W-1) check("R4 done after one bit short", ofs_done, 0);
         @(negedge clk);
      end
      sel1_sen_n = 1'b1;
      check(gaps ? "R5 done with gaps" : "R4 done", ofs_done, 1);
      check(gaps ? "R5 y with gaps" : "R4 y", y_ofs, yv);
      check(gaps ? "R5 x with gaps" : "R4 x", x_ofs, xv);
      check("R7 in_rdy serial", in_rdy, 1);
      // Extra bits after completion
      for (int i = 0; i < 3; i++) begin
         sel1_sen_n = 1'b0; sel0_sdata = ~xv[0];
         @(negedge clk);
      end
      sel1_sen_n = 1'b1;
      check("R5 y after extra bits", y_ofs, yv);
      check("R5 x after extra bits", x_ofs, xv);
   endtask

   task automatic t_parallel;
      apply_reset(2'b10);
      @(negedge clk);
      check("R7 in_rdy before load", in_rdy, 0);
      wr_en = 1'b1; wr_data = 36'hABC00155;
      #1 check("R7 first config write blocked", fifo_wr, 0);
      @(negedge clk);
      wr_data = 36'h5550000A3;
      #1 check("R7 second config write blocked", fifo_wr, 0);
      check("R6 done after one word", ofs_done, 0);
      @(negedge clk);
      wr_data = 36'h0000003FF;
      check("R6 x", x_ofs, 10'h155);
      check("R6 y", y_ofs, 10'h0A3);
      check("R6 done", ofs_done, 1);
      #1 check("R7 data write passes", fifo_wr, 1);
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 x after later write", x_ofs, 10'h155);
      check("R6 y after later write", y_ofs, 10'h0A3);
      check("R7 done sticky", ofs_done, 1);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_preset_lo();
      t_preset_hi();
      t_pins_after_reset();
      t_serial(10'h2A5, 10'h13C, 1'b0);
      t_serial(10'h301, 10'h0FE, 1'b1);
      t_parallel();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule